// File: doc/BRIEF.md
# Multi-Policy Shared Bus Arbiter

This block decides which of several processors owns a single shared bus. Every processor has its own request line and receives its own grant line. The processors share one busy line, which the current owner drives high for as long as it uses the bus. When the bus is free and at least one request is pending, the arbiter picks one requester and raises that requester's grant on the next clock edge. The grant stays up until the owner has raised busy and then dropped it again.

A two-bit mode input chooses the selection rule for each arbitration. The four rules are rotating priority, least-recently-used priority, a pseudo-random priority order, and an equal-chance draw among the pending requesters. All policy state (the rotation pointer, the usage list and the pseudo-random generator) advances once per completed tenure in every mode, so switching modes at run time never leaves stale state behind.

The controller has three states. `ST_IDLE` waits for a request on a free bus. `ST_AWAIT` holds the grant until the new owner raises busy. `ST_HOLD` holds the grant while busy stays high. The transitions are: *arbitrate* (`ST_IDLE` to `ST_AWAIT` when busy is low and any request is set), *claim* (`ST_AWAIT` to `ST_HOLD` when busy is high), and *release* (`ST_HOLD` to `ST_IDLE` when busy is low). A synchronous reset returns the controller to `ST_IDLE` from any state.

Top module: `bus_master_arbiter`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows `grant` all zero. Reset also restores the rotation order, so master 0 is highest and master N-1 lowest. It sets the usage list to index order, with master 0 as least recently used, and loads the pseudo-random register with its seed (default 16'hACE1).
- R2: If the arbiter is idle, `busy` is low and `req` is nonzero at an edge, `grant` becomes one-hot at that edge. The set bit always belongs to a master whose request was set in the sampled cycle. At no time is more than one grant bit set.
- R3: No grant is raised at an edge where `busy` is high. Requests made while the bus is busy wait until `busy` has been low at an edge.
- R4: Once raised, the grant holds through the wait for `busy` to rise and through the whole time `busy` stays high. Changes on `req` do not affect it. At the first edge in `ST_HOLD` where `busy` is low, the grant clears.
- R5: Rotating mode is `mode` = 2'b00. The scan starts at the top-priority index and moves upward, wrapping modulo N. The first requester found wins. After each tenure, every master drops one place and the previous lowest becomes the highest, so the top-priority index goes down by one, modulo N.
- R6: LRU mode is `mode` = 2'b01. The winner is the pending requester nearest the least-recently-used end of the usage list. After each tenure, the winner moves to the most-recently-used end and the others keep their relative order.
- R7: Random mode is `mode` = 2'b10. The scan starts at index (L mod N) and moves upward, wrapping. L is the current pseudo-random value.
- R8: Equal-chance mode is `mode` = 2'b11. Let C be the number of set request bits. With ranks counted from zero in ascending index order, the winner is the pending requester whose rank is L mod C.
- R9: `mode` is sampled only in the arbitration cycle. Changing it while a grant is held does not change that grant.
- R10: The pseudo-random register is 16 bits. On each step it shifts left, and the new bit 0 is the XOR of bits 15, 14, 12 and 3. It steps once per tenure, at the release edge.
- R11: The rotation pointer, the usage list and the pseudo-random register all update at the release edge, whatever the mode used for that tenure.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req | input | NUM_MASTERS | One request bit per master |
| busy | input | 1 | Shared bus-in-use line driven by the current owner |
| mode | input | 2 | Selection rule: 00 rotating, 01 LRU, 10 random, 11 equal-chance |
| grant | output | NUM_MASTERS | One-hot grant to the chosen master, zero when no grant is held |

## Verification
The properties assume that a granted master raises `busy` at some point and later lowers it. They also assume `busy` is never high when no grant is held, except on purpose to hold off arbitration. The stimulus follows that protocol. It drives `busy` high only after a grant has appeared, or in the one directed case that checks a busy bus blocks new grants. Every tenure ends with `busy` low, so the release edge always occurs and the policy state advances in a way the bench can predict.

// File: rtl/bus_arb_pkg.sv
package bus_arb_pkg;

    typedef enum logic [1:0] {
        POL_ROTATE = 2'b00,
        POL_LRU    = 2'b01,
        POL_RANDOM = 2'b10,
        POL_EQUAL  = 2'b11
    } policy_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_AWAIT = 2'b01,
        ST_HOLD  = 2'b10
    } arb_state_e;

    localparam int RND_W = 16;

    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/bus_arb_lfsr.sv
module bus_arb_lfsr #(
    parameter logic [15:0] SEED = 16'hACE1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        step,
    output logic [15:0] value
);
    // An all-zero seed would lock the register; substitute a legal one.
    localparam logic [15:0] SAFE_SEED = (SEED == 16'h0000) ? 16'h0001 : SEED;

    logic feedback;

    // Taps 16, 15, 13, 4 give a maximal-length sequence.
    assign feedback = value[15] ^ value[14] ^ value[12] ^ value[3];

    always_ff @(posedge clk) begin
        if (rst) begin
            value <= SAFE_SEED;
        end else if (step) begin
            value <= {value[14:0], feedback};
        end
    end
endmodule

// File: rtl/bus_arb_scan_pick.sv
// Circular first-set scan starting from a given index.
module bus_arb_scan_pick #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0]  req,
    input  logic [IW-1:0] start,
    output logic          found,
    output logic [IW-1:0] idx
);
    logic [IW-1:0] cand;

    always_comb begin
        found = 1'b0;
        idx   = '0;
        cand  = '0;
        for (int k = 0; k < N; k++) begin
            cand = IW'((int'(start) + k) % N);
            if (!found && req[cand]) begin
                found = 1'b1;
                idx   = cand;
            end
        end
    end
endmodule

// File: rtl/bus_arb_lru.sv
// Usage list: slot 0 is least recently used, slot N-1 most recently used.
module bus_arb_lru #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  req,
    input  logic          update,
    input  logic [IW-1:0] used_idx,
    output logic          found,
    output logic [IW-1:0] idx
);
    logic [IW-1:0] order_q [N];
    logic [IW-1:0] order_d [N];
    logic [IW-1:0] pos;

    // Winner search from the least recently used end.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int k = 0; k < N; k++) begin
            if (!found && req[order_q[k]]) begin
                found = 1'b1;
                idx   = order_q[k];
            end
        end
    end

    // Move the used index to the tail and close the gap.
    always_comb begin
        pos = '0;
        for (int k = 0; k < N; k++) begin
            if (order_q[k] == used_idx) begin
                pos = IW'(k);
            end
        end
        for (int k = 0; k < N; k++) begin
            if (k < int'(pos)) begin
                order_d[k] = order_q[k];
            end else if (k < N - 1) begin
                order_d[k] = order_q[k + 1];
            end else begin
                order_d[k] = used_idx;
            end
        end
    end

    for (genvar g = 0; g < N; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                order_q[g] <= IW'(g);
            end else if (update) begin
                order_q[g] <= order_d[g];
            end
        end
    end
endmodule

// File: rtl/bus_arb_equal_pick.sv
// Picks the pending requester whose ascending rank equals rnd mod count.
module bus_arb_equal_pick #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0]  req,
    input  logic [15:0]   rnd,
    output logic          found,
    output logic [IW-1:0] idx
);
    localparam int CW = $clog2(N + 1);

    logic [CW-1:0] count;
    logic [CW-1:0] target;
    logic [CW-1:0] rank;

    always_comb begin
        count = '0;
        for (int k = 0; k < N; k++) begin
            count = count + CW'(req[k]);
        end
    end

    always_comb begin
        target = '0;
        if (count != '0) begin
            target = CW'(rnd % 16'(count));
        end
        found = 1'b0;
        idx   = '0;
        rank  = '0;
        for (int k = 0; k < N; k++) begin
            if (req[k]) begin
                if (!found && rank == target) begin
                    found = 1'b1;
                    idx   = IW'(k);
                end
                rank = rank + CW'(1);
            end
        end
    end
endmodule

// File: rtl/bus_master_arbiter.sv
module bus_master_arbiter #(
    parameter int          NUM_MASTERS = 4,
    parameter logic [15:0] LFSR_SEED   = 16'hACE1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NUM_MASTERS-1:0] req,
    input  logic                   busy,
    input  logic [1:0]             mode,
    output logic [NUM_MASTERS-1:0] grant
);
    import bus_arb_pkg::*;

    localparam int IW = idx_width(NUM_MASTERS);

    arb_state_e             state_q, state_d;
    logic [NUM_MASTERS-1:0] grant_q;
    logic [IW-1:0]          win_q;
    logic [IW-1:0]          rot_ptr_q;
    logic [15:0]            rnd_val;
    logic [IW-1:0]          rnd_start;
    policy_e                policy;

    logic          rot_found, rnd_found, lru_found, eq_found, pick_found;
    logic [IW-1:0] rot_idx, rnd_idx, lru_idx, eq_idx, pick_idx;
    logic          arb_fire;
    logic          release_w;

    assign policy    = policy_e'(mode);
    assign rnd_start = IW'(int'(rnd_val) % NUM_MASTERS);

    // Policy pickers
    bus_arb_scan_pick #(.N(NUM_MASTERS), .IW(IW)) rot_pick_i (
        .req   (req),
        .start (rot_ptr_q),
        .found (rot_found),
        .idx   (rot_idx)
    );

    bus_arb_scan_pick #(.N(NUM_MASTERS), .IW(IW)) rnd_pick_i (
        .req   (req),
        .start (rnd_start),
        .found (rnd_found),
        .idx   (rnd_idx)
    );

    bus_arb_lru #(.N(NUM_MASTERS), .IW(IW)) lru_i (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .update   (release_w),
        .used_idx (win_q),
        .found    (lru_found),
        .idx      (lru_idx)
    );

    bus_arb_equal_pick #(.N(NUM_MASTERS), .IW(IW)) eq_pick_i (
        .req   (req),
        .rnd   (rnd_val),
        .found (eq_found),
        .idx   (eq_idx)
    );

    bus_arb_lfsr #(.SEED(LFSR_SEED)) lfsr_i (
        .clk   (clk),
        .rst   (rst),
        .step  (release_w),
        .value (rnd_val)
    );

    always_comb begin
        unique case (policy)
            POL_ROTATE: begin pick_found = rot_found; pick_idx = rot_idx; end
            POL_LRU:    begin pick_found = lru_found; pick_idx = lru_idx; end
            POL_RANDOM: begin pick_found = rnd_found; pick_idx = rnd_idx; end
            POL_EQUAL:  begin pick_found = eq_found;  pick_idx = eq_idx;  end
        endcase
    end

    assign arb_fire  = (state_q == ST_IDLE) && !busy && pick_found;
    assign release_w = (state_q == ST_HOLD) && !busy;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: arbitrate, claim, release
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (arb_fire) state_d = ST_AWAIT;
            ST_AWAIT: if (busy)     state_d = ST_HOLD;
            ST_HOLD:  if (!busy)    state_d = ST_IDLE;
            default:                state_d = ST_IDLE;
        endcase
    end

    // Outputs: registered one-hot grant and remembered winner
    always_ff @(posedge clk) begin
        if (rst) begin
            grant_q <= '0;
            win_q   <= '0;
        end else if (arb_fire) begin
            grant_q <= NUM_MASTERS'(1) << pick_idx;
            win_q   <= pick_idx;
        end else if (release_w) begin
            grant_q <= '0;
        end
    end

    // Rotation: previous lowest becomes highest after each tenure
    always_ff @(posedge clk) begin
        if (rst) begin
            rot_ptr_q <= '0;
        end else if (release_w) begin
            rot_ptr_q <= (rot_ptr_q == '0) ? IW'(NUM_MASTERS - 1) : rot_ptr_q - IW'(1);
        end
    end

    assign grant = grant_q;
endmodule

// File: rtl/bus_arb_chk.sv
module bus_arb_chk #(
    parameter int N = 4
) (
    input logic         clk,
    input logic         rst,
    input logic [N-1:0] req,
    input logic         busy,
    input logic [N-1:0] grant
);
    // R1
    reset_clear_chk: assert property (@(posedge clk) rst |=> grant == '0);

    // R2
    grant_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    // R2
    grant_to_requester_chk: assert property (@(posedge clk) disable iff (rst)
        (grant != '0 && $past(grant) == '0) |-> (($past(req) & grant) != '0));

    // R3
    no_grant_when_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (grant != '0 && $past(grant) == '0) |-> !$past(busy));

    // R4
    grant_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (grant != '0 && busy) |=> (!busy || grant == $past(grant)));

    // R4
    grant_release_chk: assert property (@(posedge clk) disable iff (rst)
        (grant != '0 && $past(grant) != '0 && $past(busy) && !busy) |=> grant == '0);
endmodule

bind bus_master_arbiter bus_arb_chk #(.N(NUM_MASTERS)) chk_i (
    .clk   (clk),
    .rst   (rst),
    .req   (req),
    .busy  (busy),
    .grant (grant)
);

// File: tb/bus_master_arbiter_tb_top.sv
module bus_master_arbiter_tb_top;
    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] req = '0;
    logic         busy = 1'b0;
    logic [1:0]   mode = 2'b00;
    logic [N-1:0] grant;

    int          checks = 0;
    int          fails  = 0;
    bit          done   = 1'b0;
    logic [15:0] model_rnd = 16'hACE1;

    always #4 clk = ~clk;

    bus_master_arbiter #(.NUM_MASTERS(N)) dut_i (
        .clk(clk), .rst(rst), .req(req), .busy(busy), .mode(mode), .grant(grant)
    );

    // Vector layout: [7:6] mode, [5:2] req, [1:0] expected winner, from reset.
    localparam logic [7:0] VECS [10] = '{
        8'b00_1111_00, 8'b00_1111_11, 8'b00_0011_00, 8'b01_1001_11,
        8'b01_1111_01, 8'b01_1010_11, 8'b00_0010_01, 8'b00_0110_01,
        8'b01_0100_10, 8'b01_1110_11
    };

    localparam logic [3:0] PATS [6] = '{4'b1111, 4'b0101, 4'b1110, 4'b0011, 4'b1000, 4'b1011};

    function automatic logic [15:0] rnd_step(input logic [15:0] v);
        return {v[14:0], v[15] ^ v[14] ^ v[12] ^ v[3]};
    endfunction

    function automatic int rnd_pick(input logic [15:0] v, input logic [3:0] r);
        int s = int'(v) % N;
        for (int k = 0; k < N; k++) begin
            if (r[(s + k) % N]) return (s + k) % N;
        end
        return 0;
    endfunction

    function automatic int eq_pick(input logic [15:0] v, input logic [3:0] r);
        int c = 0;
        int t;
        int rk = 0;
        for (int k = 0; k < N; k++) c += int'(r[k]);
        t = int'(v) % c;
        for (int k = 0; k < N; k++) begin
            if (r[k]) begin
                if (rk == t) return k;
                rk++;
            end
        end
        return 0;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // One complete tenure: arbitrate, claim, hold, release.
    task automatic tenure(input logic [1:0] m, input logic [3:0] r, input int win, input string tag);
        logic [N-1:0] exp = N'(1) << win;
        @(negedge clk); mode = m; req = r; busy = 1'b0;
        @(negedge clk);
        check(grant == exp, tag, grant, exp);
        req = '0; busy = 1'b1; mode = ~m;
        @(negedge clk);
        check(grant == exp, "R9 mode change while held", grant, exp);
        req = 4'b1111;
        @(negedge clk);
        check(grant == exp, "R4 held while busy", grant, exp);
        busy = 1'b0; req = '0;
        @(negedge clk);
        check(grant == '0, "R4 release after busy drops", grant, '0);
        model_rnd = rnd_step(model_rnd);
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1; req = '0; busy = 1'b0;
        @(negedge clk);
        @(negedge clk); rst = 1'b0;
        model_rnd = 16'hACE1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        check(grant == '0, "R1 grant clear in reset", grant, '0);
        rst = 1'b0;

        // Table: rotating (R5) and LRU (R6) interleaved, shared updates (R11).
        for (int i = 0; i < 10; i++) begin
            tenure(VECS[i][7:6], VECS[i][5:2], int'(VECS[i][1:0]),
                   (VECS[i][7:6] == 2'b00) ? "R5 R11 rotating vector" : "R6 R11 LRU vector");
        end

        // R3: busy blocks arbitration; R4: grant held while waiting for busy.
        @(negedge clk); mode = 2'b01; req = 4'b0100; busy = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(grant == '0, "R3 no grant while busy", grant, '0);
        end
        busy = 1'b0;
        @(negedge clk);
        check(grant == 4'b0100, "R3 grant after busy low", grant, 4'b0100);
        req = '0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(grant == 4'b0100, "R4 held awaiting busy", grant, 4'b0100);
        end
        busy = 1'b1;
        @(negedge clk); busy = 1'b0;
        @(negedge clk);
        check(grant == '0, "R4 release", grant, '0);
        model_rnd = rnd_step(model_rnd);

        // R7 and R10: random start from generator value.
        for (int i = 0; i < 12; i++) begin
            tenure(2'b10, PATS[i % 6], rnd_pick(model_rnd, PATS[i % 6]), "R7 R10 random pick");
        end
        // R8 and R10: equal-chance rank draw.
        for (int i = 0; i < 12; i++) begin
            tenure(2'b11, PATS[(i + 2) % 6], eq_pick(model_rnd, PATS[(i + 2) % 6]), "R8 R10 equal pick");
        end
        tenure(2'b11, 4'b0010, 1, "R8 single requester");

        // R1: reset restores orders and seed.
        do_reset();
        check(grant == '0, "R1 grant clear after reset", grant, '0);
        tenure(2'b01, 4'b1111, 0, "R1 LRU order after reset");
        tenure(2'b00, 4'b1111, 3, "R5 rotation after one tenure");
        do_reset();
        tenure(2'b00, 4'b1111, 0, "R1 rotation after reset");
        do_reset();
        tenure(2'b10, 4'b1111, rnd_pick(16'hACE1, 4'b1111), "R1 R10 seed after reset");

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule